// File: doc/BRIEF.md
# Transmit Frame Header Encapsulator

This block sits between a frame source and a bulk transfer buffer on the transmit side of a network adapter. Each outgoing frame arrives as a descriptor (payload length plus a per-frame request for checksum offload) followed by its payload bytes. The block writes a four-byte header in front of every frame and packs header and payload back to back into a transfer buffer of fixed size, reporting the byte position of each written byte inside the current transfer.

The header carries the payload length and its bitwise complement. When the transmit checksum capability is switched on, one of two flag bits is merged into the upper bits of the length word to tell the downstream engine whether to insert checksums for this frame. The complement word is taken from the plain length, before any flag is merged, so the two words are intentionally not exact complements once a flag is present.

A frame whose header and payload would not fit in the space left in the current transfer first closes that transfer; it then starts the next one at position zero. Frames too long to leave the flag bits free are discarded: their payload is consumed without output and a reject counter is incremented.

Top module: `tx_hdr_encap`

## Requirements
- R1: For an accepted frame of length L, the block writes exactly L+4 bytes in this order: length word low byte, length word high byte, complement word low byte, complement word high byte, then the L payload bytes in arrival order. A length of zero gives a header with no payload.
- R2: The complement word equals the bitwise inverse of the 16-bit plain length L, independent of any flag bit.
- R3: With the capability input high at descriptor acceptance and the offload request high, the length word is L with bit 14 (0x4000) set and bit 15 clear.
- R4: With the capability input high and the offload request low, the length word is L with bit 15 (0x8000) set and bit 14 clear.
- R5: With the capability input low, the length word is exactly L; bits 15 and 14 are both clear regardless of the offload request.
- R6: The position reported with each written byte starts at 0 in every transfer, increases by one per byte with no gaps across frame boundaries, and never exceeds the buffer size of 16384.
- R7: If the current fill plus L+4 exceeds 16384, the block raises the close strobe for one cycle with the transfer byte count equal to the current fill, then writes the frame from position 0. A frame that makes the fill exactly 16384 does not close; the next frame does.
- R8: A descriptor with length 2048 or more is rejected: no byte is written, its L payload bytes are still consumed, and the reject counter increases by one; the following frame is handled normally.
- R9: After reset the descriptor input is ready, no byte is written, the close strobe is low, the fill position is 0 and the reject counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csum_cap_en | input | 1 | Transmit checksum capability enable, sampled with each descriptor |
| desc_valid | input | 1 | Frame descriptor present |
| desc_ready | output | 1 | Descriptor accepted when high together with desc_valid |
| desc_len | input | 16 | Payload length in bytes |
| desc_offload | input | 1 | Frame asks for checksum insertion |
| pay_valid | input | 1 | Payload byte present |
| pay_ready | output | 1 | Payload byte consumed when high together with pay_valid |
| pay_byte | input | 8 | Payload byte |
| out_valid | output | 1 | A byte is written to the transfer buffer this cycle |
| out_byte | output | 8 | Byte written |
| out_pos | output | 15 | Position of the written byte in the current transfer (current fill) |
| xfer_close | output | 1 | One-cycle strobe closing the current transfer |
| xfer_bytes | output | 15 | Byte count of the transfer being closed |
| reject_count | output | 16 | Number of rejected over-length frames |

## Verification
A corrupted fill count shows on the very next written byte as a position that breaks the gapless sequence, and later as a close issued at the wrong frame or with the wrong byte count. A wrong latched flag or length shows within the first two header bytes of the frame, while a wrong remaining-byte count shows at the frame's end as a missing or extra byte, which then misplaces the next frame's header. The bench therefore compares every written byte and its position against an independent model of the header and of the buffer fill, including a transfer filled to exactly its size.

// File: rtl/txe_pkg.sv
package txe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLOSE,
    ST_HDR,
    ST_DATA,
    ST_DROP
  } txe_state_e;

  localparam logic [15:0] FLAG_INSERT = 16'h4000;
  localparam logic [15:0] FLAG_SKIP   = 16'h8000;

  // Length word: plain length with the checksum control flag merged in.
  function automatic logic [15:0] len_word(input logic [15:0] len,
                                           input logic        cap,
                                           input logic        off);
    logic [15:0] flag;
    flag = cap ? (off ? FLAG_INSERT : FLAG_SKIP) : 16'h0000;
    return len | flag;
  endfunction

  // Complement word: always taken from the unflagged length.
  function automatic logic [15:0] inv_word(input logic [15:0] len);
    return ~len;
  endfunction

  // Header byte selection, little-endian words, length word first.
  function automatic logic [7:0] hdr_byte(input logic [15:0] lw,
                                          input logic [15:0] iw,
                                          input logic [1:0]  idx);
    case (idx)
      2'd0:    return lw[7:0];
      2'd1:    return lw[15:8];
      2'd2:    return iw[7:0];
      default: return iw[15:8];
    endcase
  endfunction

endpackage

// File: rtl/txe_hdr_build.sv
module txe_hdr_build
  import txe_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] len,
  input  logic             cap,
  input  logic             off,
  input  logic [1:0]       idx,
  output logic [15:0]      lw,
  output logic [15:0]      iw,
  output logic [7:0]       hbyte
);

  always_comb begin
    lw    = len_word(len, cap, off);
    iw    = inv_word(len);
    hbyte = hdr_byte(lw, iw, idx);
  end

endmodule

// File: rtl/txe_fill_track.sv
module txe_fill_track #(
  parameter int BUF_BYTES = 16384,
  parameter int LEN_W     = 16,
  parameter int HDR_BYTES = 4,
  localparam int FILL_W   = $clog2(BUF_BYTES + 1),
  localparam int SUM_W    = (FILL_W > LEN_W ? FILL_W : LEN_W) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              clear,
  input  logic [LEN_W-1:0]  chk_len,
  output logic [FILL_W-1:0] fill,
  output logic              fits
);

  logic [SUM_W-1:0] need;

  always_comb begin
    need = SUM_W'(fill) + SUM_W'(HDR_BYTES) + SUM_W'(chk_len);
    fits = (need <= SUM_W'(BUF_BYTES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fill <= '0;
    else if (clear)  fill <= '0;
    else if (adv)    fill <= fill + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(BUF_BYTES)); // R6

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clear) |=> fill == $past(fill) + 1'b1); // R6

endmodule

// File: rtl/tx_hdr_encap.sv
module tx_hdr_encap
  import txe_pkg::*;
#(
  parameter int BUF_BYTES = 16384,
  parameter int MAX_LEN   = 2048,
  parameter int LEN_W     = 16,
  parameter int REJ_W     = 16,
  localparam int FILL_W   = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csum_cap_en,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              desc_offload,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [7:0]        pay_byte,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic [FILL_W-1:0] out_pos,
  output logic              xfer_close,
  output logic [FILL_W-1:0] xfer_bytes,
  output logic [REJ_W-1:0]  reject_count
);

  txe_state_e       state;
  logic [1:0]       idx;
  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] lat_len;
  logic             lat_off;
  logic             lat_cap;

  // Named internal events for the assertions.
  logic             take_desc;
  logic             too_long;
  logic             reject_evt;
  logic             take_pay;
  logic             fits;
  logic [FILL_W-1:0] fill;
  logic [15:0]      hdr_lw;
  logic [15:0]      hdr_iw;
  logic [7:0]       hdr_b;

  txe_hdr_build #(.LEN_W(LEN_W)) u_hdr (
    .len   (lat_len),
    .cap   (lat_cap),
    .off   (lat_off),
    .idx   (idx),
    .lw    (hdr_lw),
    .iw    (hdr_iw),
    .hbyte (hdr_b)
  );

  txe_fill_track #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_fill (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (out_valid),
    .clear   (xfer_close),
    .chk_len (desc_len),
    .fill    (fill),
    .fits    (fits)
  );

  always_comb begin
    desc_ready = (state == ST_IDLE);
    pay_ready  = (state == ST_DATA) || (state == ST_DROP);
    take_desc  = desc_valid && desc_ready;
    too_long   = (desc_len >= LEN_W'(MAX_LEN));
    reject_evt = take_desc && too_long;
    take_pay   = pay_valid && pay_ready;
    out_valid  = (state == ST_HDR) || ((state == ST_DATA) && pay_valid);
    out_byte   = (state == ST_HDR) ? hdr_b : pay_byte;
    out_pos    = fill;
    xfer_close = (state == ST_CLOSE);
    xfer_bytes = fill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      idx          <= '0;
      rem          <= '0;
      lat_len      <= '0;
      lat_off      <= 1'b0;
      lat_cap      <= 1'b0;
      reject_count <= '0;
    end else begin
      case (state)
        ST_IDLE: if (take_desc) begin
          lat_len <= desc_len;
          lat_off <= desc_offload;
          lat_cap <= csum_cap_en;
          rem     <= desc_len;
          idx     <= '0;
          if (too_long) begin
            reject_count <= reject_count + 1'b1;
            state        <= ST_DROP;
          end else begin
            state <= fits ? ST_HDR : ST_CLOSE;
          end
        end
        ST_CLOSE: state <= ST_HDR;
        ST_HDR: begin
          idx <= idx + 1'b1;
          if (idx == 2'd3) state <= (rem == '0) ? ST_IDLE : ST_DATA;
        end
        ST_DATA, ST_DROP: if (take_pay) begin
          rem <= rem - 1'b1;
          if (rem == LEN_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_HDR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR) |-> ((hdr_lw & 16'h3FFF) ^ hdr_iw) == 16'hFFFF); // R2

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR) |-> !(hdr_lw[15] && hdr_lw[14])); // R3

  AST_NO_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR && !lat_cap) |-> (hdr_lw[15:14] == 2'b00)); // R5

  AST_CLOSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_close |=> (out_valid && out_pos == '0)); // R7

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DROP) |-> !out_valid); // R8

  AST_REJ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> reject_count == $past(reject_count) + 1'b1); // R8

endmodule

// File: tb/tx_hdr_encap_test.sv
module tx_hdr_encap_test;

  localparam int CLK_PERIOD = 10;
  localparam int BUF        = 16384;
  localparam int NVEC       = 6;
  // {cap, offload, len}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 16'd60},
    {1'b1, 1'b0, 16'd61},
    {1'b0, 1'b1, 16'd63},
    {1'b0, 1'b0, 16'd1},
    {1'b1, 1'b1, 16'd0},
    {1'b1, 1'b0, 16'd1500}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csum_cap_en = 1'b0;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [15:0] desc_len = '0;
  logic        desc_offload = 1'b0;
  logic        pay_valid = 1'b0;
  logic        pay_ready;
  logic [7:0]  pay_byte = '0;
  logic        out_valid;
  logic [7:0]  out_byte;
  logic [14:0] out_pos;
  logic        xfer_close;
  logic [14:0] xfer_bytes;
  logic [15:0] reject_count;

  tx_hdr_encap uut (
    .clk(clk), .rst_n(rst_n), .csum_cap_en(csum_cap_en),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_len(desc_len),
    .desc_offload(desc_offload), .pay_valid(pay_valid), .pay_ready(pay_ready),
    .pay_byte(pay_byte), .out_valid(out_valid), .out_byte(out_byte),
    .out_pos(out_pos), .xfer_close(xfer_close), .xfer_bytes(xfer_bytes),
    .reject_count(reject_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  cap_b [4096];
  logic [14:0] cap_p [4096];
  int ncap = 0;
  int ncl = 0;
  int last_cl = 0;
  int exp_fill = 0;
  int seed = 0;
  bit seen_close = 0;

  // Monitor: values at the falling edge are committed at the next rising edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && ncap < 4096) begin
        cap_b[ncap] = out_byte;
        cap_p[ncap] = out_pos;
        ncap++;
      end
      if (xfer_close) begin
        ncl++;
        last_cl = int'(xfer_bytes);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive(input int len, input bit off, input bit cap);
    @(posedge clk); #1;
    ncap = 0;
    csum_cap_en = cap; desc_offload = off; desc_len = 16'(len); desc_valid = 1'b1;
    do @(negedge clk); while (!desc_ready);
    @(posedge clk); #1;
    desc_valid = 1'b0;
    for (int k = 0; k < len; k++) begin
      pay_valid = 1'b1;
      pay_byte = 8'(seed + k);
      do @(negedge clk); while (!pay_ready);
      @(posedge clk); #1;
    end
    pay_valid = 1'b0;
    do @(negedge clk); while (!desc_ready);
  endtask

  task automatic frame(input int len, input bit off, input bit cap);
    int cl0;
    bit want_close;
    logic [15:0] elw, eiw;
    int bad_pay, bad_pos;
    cl0 = ncl;
    want_close = (exp_fill + 4 + len > BUF);
    drive(len, off, cap);
    if (want_close) begin
      chk(ncl == cl0 + 1, "R7 close count", ncl - cl0, 1);
      chk(last_cl == exp_fill, "R7 closed byte count", last_cl, exp_fill);
      exp_fill = 0;
      seen_close = 1;
    end else begin
      chk(ncl == cl0, "R7 no close", ncl - cl0, 0);
    end
    elw = 16'(len) | (cap ? (off ? 16'h4000 : 16'h8000) : 16'h0000);
    eiw = ~16'(len);
    chk(ncap == len + 4, "R1 byte count", ncap, len + 4);
    chk({cap_b[1], cap_b[0]} == elw, cap ? (off ? "R3 length word" : "R4 length word") : "R5 length word",
        int'({cap_b[1], cap_b[0]}), int'(elw));
    chk({cap_b[3], cap_b[2]} == eiw, "R2 complement word", int'({cap_b[3], cap_b[2]}), int'(eiw));
    bad_pay = -1; bad_pos = -1;
    for (int k = 0; k < len && k + 4 < ncap; k++)
      if (bad_pay < 0 && cap_b[k+4] != 8'(seed + k)) bad_pay = k;
    for (int k = 0; k < ncap; k++)
      if (bad_pos < 0 && int'(cap_p[k]) != exp_fill + k) bad_pos = k;
    chk(bad_pay < 0, "R1 payload order", bad_pay, -1);
    chk(bad_pos < 0, "R6 positions", bad_pos, -1);
    exp_fill += 4 + len;
    chk(exp_fill <= BUF, "R6 fill bound", exp_fill, BUF);
    seed += 7;
  endtask

  task automatic reject(input int len);
    int rej0, cl0;
    rej0 = int'(reject_count);
    cl0 = ncl;
    drive(len, 1'b1, 1'b1);
    chk(ncap == 0, "R8 no output", ncap, 0);
    chk(int'(reject_count) == rej0 + 1, "R8 reject count", int'(reject_count), rej0 + 1);
    chk(ncl == cl0, "R8 no close", ncl - cl0, 0);
    seed += 3;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(desc_ready == 1'b1, "R9 desc_ready", int'(desc_ready), 1);
    chk(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
    chk(xfer_close == 1'b0, "R9 xfer_close", int'(xfer_close), 0);
    chk(out_pos == '0, "R9 out_pos", int'(out_pos), 0);
    chk(reject_count == '0, "R9 reject_count", int'(reject_count), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++)
      frame(int'(VEC[v][15:0]), VEC[v][16], VEC[v][17]);

    // R8: over-length frames, then normal handling resumes
    reject(2048);
    frame(20, 1'b0, 1'b0);
    reject(3000);
    frame(2047, 1'b1, 1'b1);

    // R7/R6: fill to a close, then fill exactly to the buffer size
    do frame(2047, 1'b0, 1'b1);
    while (!(seen_close && exp_fill + 2051 > BUF));
    frame(BUF - 4 - exp_fill, 1'b1, 1'b0);
    chk(exp_fill == BUF, "R7 exact fit reached", exp_fill, BUF);
    frame(0, 1'b0, 1'b1);
    chk(last_cl == BUF, "R7 full transfer closed", last_cl, BUF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule